// File: doc/BRIEF.md
# Interrupt Source Router

This block holds the configuration and live state of a bank of interrupt sources and decides, for each source, which CPUs should be offered it. Each source has two 32-bit registers on a simple register bus. One holds the mask, the delivery mode, the sense, the priority and the vector. The other holds the destination CPU set. The block samples each source input as level- or edge-sensitive and tracks a pending flag and an activity flag per source. It re-runs a forwarding check for a source whenever that source's input, registers or acknowledge state change.

When a check passes, the block produces a one-cycle offer strobe. The strobe carries a CPU mask and the source index, and per-CPU delivery logic consumes it. That delivery logic reports back with an activity-set pulse when it takes a source. Acknowledge logic clears activity with an activity-clear pulse. Directed sources are offered to every selected CPU. Distributed sources rotate among the selected CPUs, one CPU per offer.

Top module: `irq_router`

## Requirements
- R1: Writing the vector/priority register (offset 0x0 of a source) stores bit 31 (mask), bit 29 (distributed mode), bit 23 (polarity), bit 22 (sense, 1 = level), bits 19:16 (priority) and bits 7:0 (vector). Bit 30 reads back the activity flag and is not writable. All other bits read as zero.
- R2: After reset every vector/priority register reads 0xA0000000, every destination register reads 0, no offer is made, and each source's last-served CPU is 0.
- R3: Writing the destination register (offset 0x10 of a source) keeps bits 31:30 and one bit per CPU (bit c selects CPU c). All other bits read as zero.
- R4: A source's registers sit at address index*32. An access whose low four address bits are not zero is ignored on write and reads 0xFFFFFFFF.
- R5: A level source's pending flag follows its input, and a low input clears its activity flag. A rising edge sets an edge source's pending flag, and a falling edge does nothing. An activity-clear pulse clears the activity flag and, for an edge source, its pending flag.
- R6: A source is not offered when it is not pending, is masked, has priority 0, is active, or has a destination register of zero.
- R7: With the mode bit clear, the source is offered to every CPU selected in its destination register in one strobe.
- R8: With the mode bit set, the search starts at the CPU after the last-served one and wraps around. The first selected CPU it finds receives the offer alone and becomes the last-served CPU.
- R9: When the destination selects only the last-served CPU, the offer goes to that CPU whatever the mode.
- R10: A write to either register, an input change (for edge sources only a rising edge) or an activity-clear pulse schedules a recheck of that source. Rechecks run one source per cycle, lowest index first. A source whose input is sampled at one clock edge is offered on the next edge, and the offer strobe lasts one cycle.
- R11: An activity-set pulse marks the source active and is visible in bit 30. An active source is never re-offered until it is acknowledged or, if level-sensitive, its input falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Register address, shared by read and write |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| src_in | input | NUM_SRC | Interrupt source inputs |
| act_set_valid | input | 1 | Delivery unit took a source |
| act_set_idx | input | SIDX_W | Source index for activity set |
| act_clr_valid | input | 1 | Acknowledge of a source |
| act_clr_idx | input | SIDX_W | Source index for activity clear |
| offer_mask | output | NUM_CPU | One-cycle offer strobe, one bit per CPU |
| offer_idx | output | SIDX_W | Source index of the current offer |

## Verification
The bench walks a distributed source through a full rotation, including the wrap from the highest CPU back to CPU 0. A design that searched from the last-served CPU itself, or failed to record it, would hand out the same CPU twice. It re-raises an active edge source and expects silence, then acknowledges it and expects the pending flag gone. A design that kept pending or ignored activity would offer a source nobody can take. A level source is acknowledged while still high and must be offered again. Two sources that rise together must appear on consecutive cycles in index order, not merged or dropped. Writes that unmask a pending source must trigger an offer by themselves, and writes with priority 0 or an empty destination must not.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int VEC_W  = 8;
    localparam int PRIO_W = 4;

    // live and configured state of one source
    typedef struct packed {
        logic              mask;
        logic              act;
        logic              mode;
        logic              pol;
        logic              sense;
        logic [PRIO_W-1:0] prio;
        logic [VEC_W-1:0]  vec;
        logic [1:0]        dhi;
        logic              pend;
        logic              dirty;
    } src_state_t;

    localparam src_state_t SRC_RESET = '{
        mask: 1'b1, act: 1'b0, mode: 1'b1, pol: 1'b0, sense: 1'b0,
        prio: '0, vec: '0, dhi: '0, pend: 1'b0, dirty: 1'b0
    };

endpackage

// File: rtl/irq_rr_pick.sv
module irq_rr_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last,
    output logic          found,
    output logic [IW-1:0] pick
);
    // cyclic search beginning just after "last"
    always_comb begin
        found = 1'b0;
        pick  = last;
        for (int k = 1; k <= N; k++) begin
            int c;
            c = (int'(last) + k) % N;
            if (!found && req[c]) begin
                found = 1'b1;
                pick  = IW'(c);
            end
        end
    end
endmodule

// File: rtl/irq_first_set.sv
module irq_first_set #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int NUM_CPU = 4,
    localparam int SIDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int CIDX_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int ADDR_W = SIDX_W + 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               act_set_valid,
    input  logic [SIDX_W-1:0]  act_set_idx,
    input  logic               act_clr_valid,
    input  logic [SIDX_W-1:0]  act_clr_idx,
    output logic [NUM_CPU-1:0] offer_mask,
    output logic [SIDX_W-1:0]  offer_idx
);

    typedef struct packed {
        src_state_t [NUM_SRC-1:0]              src;
        logic [NUM_SRC-1:0][NUM_CPU-1:0]       dst;
        logic [NUM_SRC-1:0][CIDX_W-1:0]        last;
        logic [NUM_SRC-1:0]                    in;
        logic [NUM_CPU-1:0]                    offer_mask;
        logic [SIDX_W-1:0]                     offer_idx;
    } state_t;

    state_t q, d;

    // ---------------- address decode ----------------
    logic              acc_ok;
    logic [SIDX_W-1:0] acc_idx;
    logic              acc_dst;

    assign acc_idx = addr[ADDR_W-1:5];
    assign acc_dst = addr[4];
    assign acc_ok  = (addr[3:0] == 4'h0) && (32'(acc_idx) < NUM_SRC);

    always_comb begin
        src_state_t s;
        s = q.src[acc_idx];
        if (!acc_ok) begin
            rdata = 32'hFFFF_FFFF;
        end else if (acc_dst) begin
            rdata = {s.dhi, (30 - NUM_CPU)'(0), q.dst[acc_idx]};
        end else begin
            rdata = {s.mask, s.act, s.mode, 5'b0, s.pol, s.sense, 2'b0,
                     s.prio, 8'b0, s.vec};
        end
    end

    // ---------------- recheck selection ----------------
    logic [NUM_SRC-1:0] dirty_vec;
    logic               chk_any;
    logic [SIDX_W-1:0]  chk_idx;
    logic               rr_found;
    logic [CIDX_W-1:0]  rr_pick;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_dirty
        assign dirty_vec[g] = q.src[g].dirty;
    end

    irq_first_set #(.N(NUM_SRC), .IW(SIDX_W)) i_first (
        .vec (dirty_vec),
        .any (chk_any),
        .idx (chk_idx)
    );

    irq_rr_pick #(.N(NUM_CPU), .IW(CIDX_W)) i_rr (
        .req   (q.dst[chk_idx]),
        .last  (q.last[chk_idx]),
        .found (rr_found),
        .pick  (rr_pick)
    );

    // ---------------- next state ----------------
    always_comb begin
        src_state_t         c;
        logic [NUM_CPU-1:0] cpus;
        logic [NUM_CPU-1:0] last_oh;
        logic               ok;

        d            = q;
        d.in         = src_in;
        d.offer_mask = '0;
        d.offer_idx  = q.offer_idx;

        // forwarding check for one scheduled source
        c       = q.src[chk_idx];
        cpus    = q.dst[chk_idx];
        last_oh = NUM_CPU'(1) << q.last[chk_idx];
        ok      = chk_any && c.pend && !c.mask && (c.prio != '0) && !c.act &&
                  ({c.dhi, cpus} != '0);
        if (chk_any) begin
            d.src[chk_idx].dirty = 1'b0;
        end
        if (ok) begin
            d.offer_idx = chk_idx;
            if (cpus == last_oh) begin
                d.offer_mask = cpus;
            end else if (!c.mode) begin
                d.offer_mask = cpus;
            end else if (rr_found) begin
                d.offer_mask          = NUM_CPU'(1) << rr_pick;
                d.last[chk_idx]       = rr_pick;
            end
        end

        // per-source sensing, activity and register writes
        for (int i = 0; i < NUM_SRC; i++) begin
            logic rise, chg, hit_set, hit_clr, hit_wr;
            rise    = src_in[i] && !q.in[i];
            chg     = src_in[i] != q.in[i];
            hit_set = act_set_valid && (act_set_idx == SIDX_W'(i));
            hit_clr = act_clr_valid && (act_clr_idx == SIDX_W'(i));
            hit_wr  = wr_en && acc_ok && (acc_idx == SIDX_W'(i));

            if (hit_set) d.src[i].act = 1'b1;
            if (hit_clr) begin
                d.src[i].act = 1'b0;
                if (!q.src[i].sense) d.src[i].pend = 1'b0;
            end
            if (q.src[i].sense) begin
                d.src[i].pend = src_in[i];
                if (!src_in[i]) d.src[i].act = 1'b0;
            end else if (rise) begin
                d.src[i].pend = 1'b1;
            end

            if (hit_wr) begin
                if (acc_dst) begin
                    d.src[i].dhi = wdata[31:30];
                    d.dst[i]     = wdata[NUM_CPU-1:0];
                end else begin
                    d.src[i].mask  = wdata[31];
                    d.src[i].mode  = wdata[29];
                    d.src[i].pol   = wdata[23];
                    d.src[i].sense = wdata[22];
                    d.src[i].prio  = wdata[16 +: PRIO_W];
                    d.src[i].vec   = wdata[VEC_W-1:0];
                end
            end

            if (hit_wr || hit_clr || (q.src[i].sense ? chg : rise)) begin
                d.src[i].dirty = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                q.src[i]  <= SRC_RESET;
                q.dst[i]  <= '0;
                q.last[i] <= '0;
            end
            q.in         <= '0;
            q.offer_mask <= '0;
            q.offer_idx  <= '0;
        end else begin
            q <= d;
        end
    end

    assign offer_mask = q.offer_mask;
    assign offer_idx  = q.offer_idx;

    // state views for the bound checker
    logic [NUM_SRC-1:0] mask_bits, act_bits, pend_bits, mode_bits, sense_bits;
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_view
        assign mask_bits[g]  = q.src[g].mask;
        assign act_bits[g]   = q.src[g].act;
        assign pend_bits[g]  = q.src[g].pend;
        assign mode_bits[g]  = q.src[g].mode;
        assign sense_bits[g] = q.src[g].sense;
    end

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
    parameter int NUM_SRC = 8,
    parameter int NUM_CPU = 4,
    localparam int SIDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int ADDR_W = SIDX_W + 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  addr,
    input logic [31:0]        rdata,
    input logic [NUM_SRC-1:0] src_in,
    input logic [NUM_CPU-1:0] offer_mask,
    input logic [SIDX_W-1:0]  offer_idx,
    input logic [NUM_SRC-1:0] mask_bits,
    input logic [NUM_SRC-1:0] act_bits,
    input logic [NUM_SRC-1:0] pend_bits,
    input logic [NUM_SRC-1:0] mode_bits,
    input logic [NUM_SRC-1:0] sense_bits
);
    logic [NUM_SRC-1:0] mask_p, act_p, pend_p, mode_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_p <= '1;
            act_p  <= '0;
            pend_p <= '0;
            mode_p <= '1;
        end else begin
            mask_p <= mask_bits;
            act_p  <= act_bits;
            pend_p <= pend_bits;
            mode_p <= mode_bits;
        end
    end

    // R4: unaligned reads return all ones
    p_misaligned_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[3:0] != 4'h0) |-> (rdata == 32'hFFFF_FFFF));

    // R6: an offer only follows a pending, unmasked, inactive source
    p_offer_eligible_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|offer_mask) |-> (pend_p[offer_idx] && !mask_p[offer_idx] && !act_p[offer_idx]));

    // R8: distributed offers go to exactly one CPU
    p_dist_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((|offer_mask) && mode_p[offer_idx]) |-> $onehot(offer_mask));

    // R5: a low level input drops activity
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_lvl
        p_level_low_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (sense_bits[g] && !src_in[g]) |=> !act_bits[g]);
    end
endmodule

bind irq_router irq_router_chk #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .rdata      (rdata),
    .src_in     (src_in),
    .offer_mask (offer_mask),
    .offer_idx  (offer_idx),
    .mask_bits  (mask_bits),
    .act_bits   (act_bits),
    .pend_bits  (pend_bits),
    .mode_bits  (mode_bits),
    .sense_bits (sense_bits)
);

// File: tb/test_irq_router.sv
module test_irq_router;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_SRC = 8;
    localparam int NUM_CPU = 4;
    localparam int SIDX_W = 3;
    localparam int ADDR_W = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [ADDR_W-1:0]  addr = '0;
    logic               wr_en = 1'b0;
    logic [31:0]        wdata = '0;
    logic [31:0]        rdata;
    logic [NUM_SRC-1:0] src_in = '0;
    logic               act_set_valid = 1'b0;
    logic [SIDX_W-1:0]  act_set_idx = '0;
    logic               act_clr_valid = 1'b0;
    logic [SIDX_W-1:0]  act_clr_idx = '0;
    logic [NUM_CPU-1:0] offer_mask;
    logic [SIDX_W-1:0]  offer_idx;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_router #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) i_irq_router (
        .clk, .rst_n, .addr, .wr_en, .wdata, .rdata, .src_in,
        .act_set_valid, .act_set_idx, .act_clr_valid, .act_clr_idx,
        .offer_mask, .offer_idx
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, got, exp);
        end
    endtask

    task automatic wreg(input logic [ADDR_W-1:0] a, input logic [31:0] v);
        @(negedge clk);
        addr = a; wdata = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rreg(input logic [ADDR_W-1:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic expect_offer(input string req, input logic [NUM_CPU-1:0] m, input int idx);
        check({req, " mask"}, 32'(offer_mask), 32'(m));
        if (m != '0) check({req, " idx"}, 32'(offer_idx), 32'(idx));
    endtask

    // set an input and advance to the cycle where its offer is visible
    task automatic drive_in(input int i, input logic v);
        @(negedge clk);
        src_in[i] = v;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_set(input int i);
        @(negedge clk);
        act_set_valid = 1'b1; act_set_idx = SIDX_W'(i);
        @(negedge clk);
        act_set_valid = 1'b0;
    endtask

    task automatic pulse_clr(input int i);
        @(negedge clk);
        act_clr_valid = 1'b1; act_clr_idx = SIDX_W'(i);
        @(negedge clk);
        act_clr_valid = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        expect_offer("R2 reset", '0, 0);
        rreg(8'h00, v); check("R2 vp reset", v, 32'hA000_0000);
        rreg(8'h10, v); check("R2 dst reset", v, 32'h0);
    endtask

    task automatic t_regs;
        logic [31:0] v;
        wreg(8'hE0, 32'hFFFF_FFFF);
        rreg(8'hE0, v); check("R1 vp write mask", v, 32'hA0CF_00FF);
        wreg(8'hF0, 32'hFFFF_FFFF);
        rreg(8'hF0, v); check("R3 dst write mask", v, 32'hC000_000F);
        wreg(8'hE4, 32'h0);
        rreg(8'hE0, v); check("R4 unaligned write ignored", v, 32'hA0CF_00FF);
        rreg(8'h04, v); check("R4 unaligned read", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_directed;
        logic [31:0] v;
        wreg(8'h20, 32'h0005_0021);
        wreg(8'h30, 32'h5);
        drive_in(1, 1'b1); expect_offer("R7 directed", 4'h5, 1);
        @(negedge clk); expect_offer("R10 one-cycle strobe", '0, 0);
        pulse_set(1);
        rreg(8'h20, v); check("R11 activity bit", v, 32'h4005_0021);
        drive_in(1, 1'b0); expect_offer("R5 edge fall quiet", '0, 0);
        drive_in(1, 1'b1); expect_offer("R11 active not re-offered", '0, 0);
        pulse_clr(1);
        @(negedge clk); expect_offer("R5 ack clears edge pending", '0, 0);
        rreg(8'h20, v); check("R5 ack clears activity", v, 32'h0005_0021);
        drive_in(1, 1'b0);
        drive_in(1, 1'b1); expect_offer("R7 re-raise", 4'h5, 1);
        wreg(8'h20, 32'h8005_0021);
        @(negedge clk); expect_offer("R6 masked", '0, 0);
        wreg(8'h20, 32'h0005_0021);
        @(negedge clk); expect_offer("R10 write rechecks", 4'h5, 1);
        wreg(8'h20, 32'h0000_0021);
        @(negedge clk); expect_offer("R6 priority zero", '0, 0);
        wreg(8'h30, 32'h0);
        wreg(8'h20, 32'h0005_0021);
        @(negedge clk); expect_offer("R6 no destination", '0, 0);
    endtask

    task automatic t_level;
        logic [31:0] v;
        wreg(8'h40, 32'h0043_0042);
        wreg(8'h50, 32'h2);
        drive_in(2, 1'b1); expect_offer("R5 level offer", 4'h2, 2);
        pulse_set(2);
        rreg(8'h40, v); check("R11 level active", v, 32'h4043_0042);
        pulse_clr(2);
        @(negedge clk); expect_offer("R10 ack re-offers held level", 4'h2, 2);
        pulse_set(2);
        drive_in(2, 1'b0); expect_offer("R5 level low no offer", '0, 0);
        rreg(8'h40, v); check("R5 level low clears activity", v, 32'h0043_0042);
    endtask

    task automatic t_distributed;
        wreg(8'h60, 32'h2002_0003);
        wreg(8'h70, 32'hB);
        drive_in(3, 1'b1); expect_offer("R8 rotate first", 4'h2, 3);
        drive_in(3, 1'b0); expect_offer("R8 fall quiet", '0, 0);
        drive_in(3, 1'b1); expect_offer("R8 rotate skip", 4'h8, 3);
        drive_in(3, 1'b0);
        drive_in(3, 1'b1); expect_offer("R8 rotate wrap", 4'h1, 3);
        drive_in(3, 1'b0);
        drive_in(3, 1'b1); expect_offer("R8 rotate again", 4'h2, 3);
        wreg(8'h70, 32'h2);
        @(negedge clk); expect_offer("R9 sole last-served", 4'h2, 3);
        wreg(8'h70, 32'h4);
        @(negedge clk); expect_offer("R8 last kept by sole path", 4'h4, 3);
    endtask

    task automatic t_order;
        wreg(8'h80, 32'h0001_0004);
        wreg(8'h90, 32'h1);
        wreg(8'hA0, 32'h0001_0005);
        wreg(8'hB0, 32'h1);
        @(negedge clk);
        src_in[4] = 1'b1; src_in[5] = 1'b1;
        @(negedge clk);
        @(negedge clk); expect_offer("R10 order first", 4'h1, 4);
        @(negedge clk); expect_offer("R10 order second", 4'h1, 5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_directed();
        t_level();
        t_distributed();
        t_order();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog R10 actual=timeout expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule